// File: doc/BRIEF.md
# Correctable Error Capture Register

This block logs error-correction events for a backup cache whose data path carries a 7-bit check code on each 32-bit longword. The cache controller strobes a single-bit error along with four lane syndromes and two side flags. Each side flag says whether the fault came from the cache data (1) or from the processor side (0). On the first correctable error the register latches that context and sets its error flag. It then freezes. Any further correctable error only raises a missed-error flag. Outside an error, every cache access strobe refreshes a snapshot of the valid, dirty and shared bits and the control-bit parity of the location touched. That snapshot also freezes once the error flag is set.

Software sees the register as two 32-bit words through a simple select/write/address bus. Reads are combinational and have no side effects. Both flags are write-1-to-clear. When error correction is disabled, a single-bit error bypasses the register entirely and pulses a separate uncorrectable-error output instead.

Control is a two-state machine. In `ST_ARMED` the captured fields follow the inputs. The transition *capture* (a correctable error) moves it to `ST_HELD`, where the fields are frozen. The transition *release* (a write-1 to the error flag with no error in the same cycle) returns it to `ST_ARMED`. A correctable error in `ST_HELD` keeps the state and sets the missed flag.

Top module: `cerr_capture_reg`

## Requirements
- R1: After reset both words read zero and `uncorr_err` is low.
- R2: A correctable error (`err_strobe` with `corr_en` high) while the error flag is clear loads each lane's syndrome and sets the error flag. The flag is at upper-word bit 3. The syndromes sit as follows: lane 0 at lower bits 24:18, lane 2 at lower bits 31:25, lane 1 at upper bits 24:18, lane 3 at upper bits 31:25.
- R3: On the same capture, `err_src[0]` is stored at lower-word bit 17 and `err_src[1]` at upper-word bit 17. A stored 1 means the cache data caused the error.
- R4: While the error flag is clear, `acc_strobe` loads valid, dirty, shared and parity into lower-word bits 11, 10, 9 and 8 respectively.
- R5: While the error flag is set, syndromes, source bits and status bits hold, whatever errors or accesses arrive. A correctable error in this state sets the missed flag at upper-word bit 2.
- R6: Writing the upper word clears the error flag where data bit 3 is 1 and the missed flag where bit 2 is 1. Zero bits leave the flags unchanged.
- R7: A correctable error in the same cycle as a write-1 clear of the error flag leaves the error flag set.
- R8: A single-bit error with `corr_en` low pulses `uncorr_err` high for exactly the next cycle. It changes neither flag nor any captured field.
- R9: Lower bits 16:12 and 7:0, and upper bits 16:4 and 1:0, read zero. Writes to any field other than the two flags have no effect.
- R10: A read changes no state.
- R11: A correctable error in the same cycle as a write-1 clear of the missed flag leaves the missed flag set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| err_strobe | input | 1 | Single-bit error detected this cycle |
| corr_en | input | 1 | Error correction enabled |
| err_syn | input | 28 | Lane syndromes, lane n at bits 7n+6:7n |
| err_src | input | 2 | Fault side per half, 1 = cache data |
| acc_strobe | input | 1 | Cache location accessed this cycle |
| acc_valid | input | 1 | Valid bit of accessed location |
| acc_dirty | input | 1 | Dirty bit of accessed location |
| acc_shared | input | 1 | Shared bit of accessed location |
| acc_ctl_par | input | 1 | Control-bit parity of accessed location |
| csr_sel | input | 1 | Register access |
| csr_wr | input | 1 | 1 = write, 0 = read |
| csr_addr | input | 1 | 0 = lower word, 1 = upper word |
| csr_wdata | input | 32 | Write data |
| csr_rdata | output | 32 | Read data, zero when not reading |
| uncorr_err | output | 1 | One-cycle pulse for a single-bit error with correction off |

## Verification
The assertions assume the controller never raises `err_strobe` during reset. They also assume `err_syn` and `err_src` are stable in the strobe cycle. The read-side-effect property further assumes no error strobe coincides with the read. The bench drives every input on the falling edge and holds strobes for exactly one rising edge. It keeps error strobes out of the cycles in which it performs reads. Same-cycle error-and-clear cases are driven only where the requirements define the winner.

// File: rtl/cerr_pkg.sv
package cerr_pkg;
    localparam int LANES    = 4;
    localparam int SYN_W    = 7;
    localparam int WORD_W   = 32;
    localparam int HALVES   = 2;
    localparam int SYN_BASE = 18;
    localparam int SRC_BIT  = 17;
    localparam int ST_LSB   = 8;
    localparam int ST_W     = 4;
    localparam int CE_BIT   = 3;
    localparam int MISS_BIT = 2;
    localparam int SYN_BUS  = LANES * SYN_W;

    typedef enum logic {
        ST_ARMED = 1'b0,
        ST_HELD  = 1'b1
    } cap_state_e;

    typedef logic [SYN_W-1:0] syn_t;
endpackage

// File: rtl/cerr_fsm.sv
module cerr_fsm
    import cerr_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic err_strobe,
    input  logic corr_en,
    input  logic clr_ce,
    input  logic clr_miss,
    output logic ce_flag,
    output logic miss_flag,
    output logic load_err,
    output logic capture_en,
    output logic uncorr_err
);
    cap_state_e state_q, state_d;
    logic       ce_hit;
    logic       miss_q;
    logic       uncorr_q;

    assign ce_hit = err_strobe && corr_en;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_ARMED;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_ARMED: if (ce_hit) state_d = ST_HELD;
            ST_HELD:  if (clr_ce && !ce_hit) state_d = ST_ARMED;
            default:  state_d = ST_ARMED;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            miss_q   <= 1'b0;
            uncorr_q <= 1'b0;
        end else begin
            uncorr_q <= err_strobe && !corr_en;
            if (state_q == ST_HELD && ce_hit) begin
                miss_q <= 1'b1;
            end else if (clr_miss) begin
                miss_q <= 1'b0;
            end
        end
    end

    always_comb begin
        ce_flag    = (state_q == ST_HELD);
        capture_en = (state_q == ST_ARMED);
        load_err   = (state_q == ST_ARMED) && ce_hit;
        miss_flag  = miss_q;
        uncorr_err = uncorr_q;
    end

    p_miss_set_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (ce_flag && err_strobe && corr_en) |=> miss_flag);

    p_err_wins_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (err_strobe && corr_en && clr_ce) |=> ce_flag);

    p_miss_wins_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (ce_flag && err_strobe && corr_en && clr_miss) |=> miss_flag);
endmodule

// File: rtl/cerr_fields.sv
module cerr_fields
    import cerr_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 load_err,
    input  logic                 capture_en,
    input  logic [SYN_BUS-1:0]   err_syn,
    input  logic [HALVES-1:0]    err_src,
    input  logic                 acc_strobe,
    input  logic [ST_W-1:0]      acc_stat,
    output syn_t                 syn_q [LANES],
    output logic [HALVES-1:0]    src_q,
    output logic [ST_W-1:0]      stat_q
);
    for (genvar l = 0; l < LANES; l++) begin : g_lane
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                syn_q[l] <= '0;
            end else if (load_err) begin
                syn_q[l] <= err_syn[l*SYN_W +: SYN_W];
            end
        end

        p_lane_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
            !capture_en |=> $stable(syn_q[l]));
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            src_q <= '0;
        end else if (load_err) begin
            src_q <= err_src;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stat_q <= '0;
        end else if (capture_en && acc_strobe) begin
            stat_q <= acc_stat;
        end
    end

    p_ctx_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !capture_en |=> ($stable(src_q) && $stable(stat_q)));
endmodule

// File: rtl/cerr_csr.sv
module cerr_csr
    import cerr_pkg::*;
(
    input  logic                 csr_sel,
    input  logic                 csr_wr,
    input  logic                 csr_addr,
    input  logic [WORD_W-1:0]    csr_wdata,
    input  syn_t                 syn_q [LANES],
    input  logic [HALVES-1:0]    src_q,
    input  logic [ST_W-1:0]      stat_q,
    input  logic                 ce_flag,
    input  logic                 miss_flag,
    output logic                 clr_ce,
    output logic                 clr_miss,
    output logic [WORD_W-1:0]    csr_rdata
);
    logic [WORD_W-1:0] words [HALVES];
    logic              upper_wr;
    logic              unused_wbits;

    assign upper_wr     = csr_sel && csr_wr && csr_addr;
    assign clr_ce       = upper_wr && csr_wdata[CE_BIT];
    assign clr_miss     = upper_wr && csr_wdata[MISS_BIT];
    assign unused_wbits = ^{csr_wdata[WORD_W-1:CE_BIT+1], csr_wdata[MISS_BIT-1:0]};

    always_comb begin
        for (int h = 0; h < HALVES; h++) begin
            words[h] = '0;
            words[h][SRC_BIT] = src_q[h];
        end
        for (int l = 0; l < LANES; l++) begin
            words[l % HALVES][SYN_BASE + (l / HALVES) * SYN_W +: SYN_W] = syn_q[l];
        end
        words[0][ST_LSB +: ST_W] = stat_q;
        words[1][CE_BIT]         = ce_flag;
        words[1][MISS_BIT]       = miss_flag;
    end

    always_comb begin
        if (csr_sel && !csr_wr) begin
            csr_rdata = words[csr_addr];
        end else begin
            csr_rdata = '0;
        end
    end
endmodule

// File: rtl/cerr_capture_reg.sv
module cerr_capture_reg
    import cerr_pkg::*;
(
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       err_strobe,
    input  logic                       corr_en,
    input  logic [SYN_BUS-1:0]         err_syn,
    input  logic [HALVES-1:0]          err_src,
    input  logic                       acc_strobe,
    input  logic                       acc_valid,
    input  logic                       acc_dirty,
    input  logic                       acc_shared,
    input  logic                       acc_ctl_par,
    input  logic                       csr_sel,
    input  logic                       csr_wr,
    input  logic                       csr_addr,
    input  logic [WORD_W-1:0]          csr_wdata,
    output logic [WORD_W-1:0]          csr_rdata,
    output logic                       uncorr_err
);
    logic              ce_flag;
    logic              miss_flag;
    logic              load_err;
    logic              capture_en;
    logic              clr_ce;
    logic              clr_miss;
    syn_t              syn_q [LANES];
    logic [HALVES-1:0] src_q;
    logic [ST_W-1:0]   stat_q;

    cerr_fsm u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .err_strobe (err_strobe),
        .corr_en    (corr_en),
        .clr_ce     (clr_ce),
        .clr_miss   (clr_miss),
        .ce_flag    (ce_flag),
        .miss_flag  (miss_flag),
        .load_err   (load_err),
        .capture_en (capture_en),
        .uncorr_err (uncorr_err)
    );

    cerr_fields u_fields (
        .clk        (clk),
        .rst_n      (rst_n),
        .load_err   (load_err),
        .capture_en (capture_en),
        .err_syn    (err_syn),
        .err_src    (err_src),
        .acc_strobe (acc_strobe),
        .acc_stat   ({acc_valid, acc_dirty, acc_shared, acc_ctl_par}),
        .syn_q      (syn_q),
        .src_q      (src_q),
        .stat_q     (stat_q)
    );

    cerr_csr u_csr (
        .csr_sel    (csr_sel),
        .csr_wr     (csr_wr),
        .csr_addr   (csr_addr),
        .csr_wdata  (csr_wdata),
        .syn_q      (syn_q),
        .src_q      (src_q),
        .stat_q     (stat_q),
        .ce_flag    (ce_flag),
        .miss_flag  (miss_flag),
        .clr_ce     (clr_ce),
        .clr_miss   (clr_miss),
        .csr_rdata  (csr_rdata)
    );

    p_capture_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (err_strobe && corr_en) |=> ce_flag);

    p_uncorr_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (err_strobe && !corr_en) |=> uncorr_err);

    p_no_ce_when_off_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (err_strobe && !corr_en) |=> !$rose(ce_flag));

    p_read_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (csr_sel && !csr_wr && !err_strobe) |=> ($stable(ce_flag) && $stable(miss_flag)));
endmodule

// File: tb/cerr_capture_reg_bench.sv
module cerr_capture_reg_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        err_strobe = 1'b0;
    logic        corr_en = 1'b1;
    logic [27:0] err_syn = '0;
    logic [1:0]  err_src = '0;
    logic        acc_strobe = 1'b0;
    logic        acc_valid = 1'b0;
    logic        acc_dirty = 1'b0;
    logic        acc_shared = 1'b0;
    logic        acc_ctl_par = 1'b0;
    logic        csr_sel = 1'b0;
    logic        csr_wr = 1'b0;
    logic        csr_addr = 1'b0;
    logic [31:0] csr_wdata = '0;
    logic [31:0] csr_rdata;
    logic        uncorr_err;

    int n_checks = 0;
    int n_fail   = 0;

    logic [6:0] e_syn [4];
    logic [1:0] e_src;
    logic [3:0] e_stat;
    logic       e_ce;
    logic       e_miss;

    always #4 clk = ~clk;

    cerr_capture_reg u_cerr_capture_reg (
        .clk(clk), .rst_n(rst_n), .err_strobe(err_strobe), .corr_en(corr_en),
        .err_syn(err_syn), .err_src(err_src), .acc_strobe(acc_strobe),
        .acc_valid(acc_valid), .acc_dirty(acc_dirty), .acc_shared(acc_shared),
        .acc_ctl_par(acc_ctl_par), .csr_sel(csr_sel), .csr_wr(csr_wr),
        .csr_addr(csr_addr), .csr_wdata(csr_wdata), .csr_rdata(csr_rdata),
        .uncorr_err(uncorr_err)
    );

    function automatic logic [31:0] exp_lo();
        return {e_syn[2], e_syn[0], e_src[0], 5'b0, e_stat, 8'b0};
    endfunction

    function automatic logic [31:0] exp_hi();
        return {e_syn[3], e_syn[1], e_src[1], 13'b0, e_ce, e_miss, 2'b0};
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: got %08h expected %08h", req, act, exp);
        end
    endtask

    task automatic rd(input logic addr, output logic [31:0] val);
        @(negedge clk);
        csr_sel = 1'b1; csr_wr = 1'b0; csr_addr = addr;
        #1 val = csr_rdata;
        @(negedge clk);
        csr_sel = 1'b0;
    endtask

    task automatic check_words(input string req);
        logic [31:0] v;
        rd(1'b0, v); check(req, v, exp_lo());
        rd(1'b1, v); check(req, v, exp_hi());
    endtask

    task automatic fire_err(input logic [27:0] syn, input logic [1:0] src,
                            input logic en, input logic do_wr, input logic [31:0] wd);
        @(negedge clk);
        err_strobe = 1'b1; corr_en = en; err_syn = syn; err_src = src;
        if (do_wr) begin
            csr_sel = 1'b1; csr_wr = 1'b1; csr_addr = 1'b1; csr_wdata = wd;
        end
        @(negedge clk);
        err_strobe = 1'b0; corr_en = 1'b1; csr_sel = 1'b0; csr_wr = 1'b0;
    endtask

    task automatic wr(input logic addr, input logic [31:0] wd);
        @(negedge clk);
        csr_sel = 1'b1; csr_wr = 1'b1; csr_addr = addr; csr_wdata = wd;
        @(negedge clk);
        csr_sel = 1'b0; csr_wr = 1'b0;
    endtask

    task automatic access(input logic [3:0] st);
        @(negedge clk);
        acc_strobe = 1'b1;
        {acc_valid, acc_dirty, acc_shared, acc_ctl_par} = st;
        @(negedge clk);
        acc_strobe = 1'b0;
    endtask

    function automatic void set_syn(input logic [27:0] syn);
        for (int l = 0; l < 4; l++) e_syn[l] = syn[l*7 +: 7];
    endfunction

    task automatic t_reset();
        for (int l = 0; l < 4; l++) e_syn[l] = '0;
        e_src = '0; e_stat = '0; e_ce = 0; e_miss = 0;
        check_words("R1 reset");
        check("R1 uncorr", {31'b0, uncorr_err}, 32'h0);
    endtask

    task automatic t_status();
        access(4'b1011);
        e_stat = 4'b1011;
        check_words("R4 status capture");
        access(4'b0110);
        e_stat = 4'b0110;
        check_words("R4 status refresh");
    endtask

    task automatic t_capture();
        logic [27:0] s = {7'h55, 7'h2A, 7'h13, 7'h4C};
        fire_err(s, 2'b01, 1'b1, 1'b0, '0);
        set_syn(s); e_src = 2'b01; e_ce = 1;
        check_words("R2 R3 capture");
    endtask

    task automatic t_missed();
        fire_err({7'h7F, 7'h01, 7'h02, 7'h03}, 2'b10, 1'b1, 1'b0, '0);
        access(4'b1111);
        e_miss = 1;
        check_words("R5 frozen, missed set");
    endtask

    task automatic t_ro_write();
        wr(1'b0, 32'hFFFF_FFFF);
        wr(1'b1, 32'hFFFF_FFF3);
        check_words("R9 read-only writes ignored");
    endtask

    task automatic t_read_quiet();
        logic [31:0] v;
        for (int i = 0; i < 3; i++) rd(1'b1, v);
        check_words("R10 reads leave state");
    endtask

    task automatic t_w1c();
        wr(1'b1, 32'h0000_0004);
        e_miss = 0;
        check_words("R6 clear missed only");
    endtask

    task automatic t_races();
        fire_err({7'h11, 7'h22, 7'h33, 7'h44}, 2'b11, 1'b1, 1'b1, 32'h0000_0008);
        e_miss = 1;
        check_words("R7 error beats flag clear");
        fire_err({7'h11, 7'h22, 7'h33, 7'h44}, 2'b11, 1'b1, 1'b1, 32'h0000_0004);
        check_words("R11 error beats missed clear");
        wr(1'b1, 32'h0000_000C);
        e_ce = 0; e_miss = 0;
        check_words("R6 clear both");
    endtask

    task automatic t_disabled();
        fire_err({7'h0F, 7'h0E, 7'h0D, 7'h0C}, 2'b11, 1'b0, 1'b0, '0);
        check("R8 uncorr pulse", {31'b0, uncorr_err}, 32'h1);
        @(negedge clk);
        check("R8 uncorr one cycle", {31'b0, uncorr_err}, 32'h0);
        check_words("R8 no capture when disabled");
    endtask

    task automatic t_recapture();
        logic [27:0] s = {7'h21, 7'h43, 7'h65, 7'h07};
        fire_err(s, 2'b10, 1'b1, 1'b0, '0);
        set_syn(s); e_src = 2'b10; e_ce = 1;
        check_words("R2 R3 recapture after clear");
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_status();
        t_capture();
        t_missed();
        t_ro_write();
        t_read_quiet();
        t_w1c();
        t_races();
        t_disabled();
        t_recapture();
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        #(200000 * 8);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end
endmodule